// File: doc/BRIEF.md
# Root Port MSI Interrupt Decoder

This block sits behind the link side of a root port and turns incoming message-signalled interrupts into level interrupts for a system interrupt controller. The upstream logic has already parsed each MSI memory write into its data word and its first byte-enable field. The decoder takes the vector number from the low data bits and records it in a 64-bit pending register. A 64-bit mask register sits alongside it. The decoder drives two interrupt lines: one covers vectors 0 to 31 and the other covers vectors 32 to 63. Each line is high while any of its vectors is pending and not masked.

An MSI whose first byte-enable field is not all ones does not comply with the protocol. The decoder discards it without a trace. The block also tracks the four legacy INTx wires. It does this from assert and deassert messages, and it drives a single legacy line from them. Reception works only while the port runs in root mode. In endpoint mode, every incoming message is ignored.

Software uses a small register port. It can read the pending bits, clear them by writing ones, and read or write the mask.

Top module: `msi_irq_decoder`

## Requirements
- R1: After reset, pending is all zeros, mask is all ones, the four INTx level bits are zero, and all three interrupt outputs are low.
- R2: When `root_mode` is high, an MSI with `msi_valid` high and `msi_first_be` equal to 4'b1111 sets the pending bit numbered `msi_data[5:0]` at the next clock edge. All higher data bits are ignored.
- R3: An MSI whose `msi_first_be` is any value other than 4'b1111 is dropped. No pending bit changes.
- R4: While `root_mode` is low, MSI and INTx messages change neither the pending bits nor the INTx level bits.
- R5: A register write to address 0 (pending bits 31:0) or address 1 (pending bits 63:32) clears each pending bit whose write-data bit is 1. Pending bits whose write-data bit is 0 are untouched.
- R6: If an accepted MSI sets a pending bit in the same cycle that a register write clears that bit, the bit ends up set. Other bits cleared in that write are still cleared.
- R7: `irq_msi_lo` is high exactly when some bit in pending[31:0] & ~mask[31:0] is 1. `irq_msi_hi` does the same for bits 63:32.
- R8: Address 2 reads and writes mask[31:0], and address 3 reads and writes mask[63:32]. A masked vector still sets and holds its pending bit. Only its output contribution is blocked.
- R9: An INTx message with `intx_valid` high selects its wire with `intx_pin`, where 0=A, 1=B, 2=C and 3=D. The wire's level bit is set when `intx_assert` is 1 and cleared when it is 0. `irq_legacy` is the OR of the four level bits.
- R10: `reg_rdata` combinationally shows the register selected by `reg_addr`: 0 and 1 show the pending halves, and 2 and 3 show the mask halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| root_mode | input | 1 | 1 = root port, so messages are accepted |
| msi_valid | input | 1 | An MSI write is presented this cycle |
| msi_data | input | 32 | MSI data word; bits 5:0 give the vector |
| msi_first_be | input | 4 | First byte-enable field of the MSI write |
| intx_valid | input | 1 | A legacy INTx message is presented |
| intx_assert | input | 1 | 1 = assert message, 0 = deassert message |
| intx_pin | input | 2 | INTx wire: 0=A, 1=B, 2=C, 3=D |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| irq_msi_lo | output | 1 | Level interrupt for vectors 0 to 31 |
| irq_msi_hi | output | 1 | Level interrupt for vectors 32 to 63 |
| irq_legacy | output | 1 | Level interrupt for INTA to INTD |

## Verification
Two functions can fall in the same cycle. One is the arrival of an accepted MSI and the other is a software write-1-to-clear of the pending register. The bench provokes this in a single cycle. It first leaves one vector pending. It then presents an MSI for a second vector while writing a clear word that covers both vectors. The result is judged by reading the pending half back after the edge. The freshly signalled bit must remain set, and the other covered bit must be gone.

// File: rtl/msi_irq_decoder.sv
module msi_irq_decoder #(
  parameter int NVEC = 64,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          root_mode,
  input  logic          msi_valid,
  input  logic [DW-1:0] msi_data,
  input  logic [3:0]    msi_first_be,
  input  logic          intx_valid,
  input  logic          intx_assert,
  input  logic [1:0]    intx_pin,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_msi_lo,
  output logic          irq_msi_hi,
  output logic          irq_legacy
);
  localparam int VW   = $clog2(NVEC);
  localparam int HALF = NVEC / 2;

  logic [NVEC-1:0] pend_q, mask_q, set_vec, clr_vec;
  logic [3:0]      intx_q;
  logic            msi_hit;

  assign msi_hit = root_mode && msi_valid && (msi_first_be == 4'hF);

  always_comb begin
    set_vec = '0;
    if (msi_hit) set_vec[msi_data[VW-1:0]] = 1'b1;
    clr_vec = '0;
    if (reg_wr && reg_addr == 2'd0) clr_vec[HALF-1:0]    = reg_wdata[HALF-1:0];
    if (reg_wr && reg_addr == 2'd1) clr_vec[NVEC-1:HALF] = reg_wdata[HALF-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      mask_q <= '1;
      intx_q <= '0;
    end else begin
      pend_q <= (pend_q & ~clr_vec) | set_vec;
      if (reg_wr && reg_addr == 2'd2) mask_q[HALF-1:0]    <= reg_wdata[HALF-1:0];
      if (reg_wr && reg_addr == 2'd3) mask_q[NVEC-1:HALF] <= reg_wdata[HALF-1:0];
      if (root_mode && intx_valid) intx_q[intx_pin] <= intx_assert;
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = pend_q[HALF-1:0];
      2'd1:    reg_rdata = pend_q[NVEC-1:HALF];
      2'd2:    reg_rdata = mask_q[HALF-1:0];
      default: reg_rdata = mask_q[NVEC-1:HALF];
    endcase
  end

  assign irq_msi_lo = |(pend_q[HALF-1:0] & ~mask_q[HALF-1:0]);
  assign irq_msi_hi = |(pend_q[NVEC-1:HALF] & ~mask_q[NVEC-1:HALF]);
  assign irq_legacy = |intx_q;

  assert_drop_badbe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && msi_first_be != 4'hF && !reg_wr) |=> $stable(pend_q));

  assert_endpoint_ignore_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!root_mode && !reg_wr) |=> ($stable(pend_q) && $stable(intx_q)));

  assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (root_mode && msi_valid && msi_first_be == 4'hF) |=> pend_q[$past(msi_data[VW-1:0])]);

  assert_clear_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && !msi_valid) |=> ((pend_q[HALF-1:0] & $past(reg_wdata[HALF-1:0])) == '0));

  assert_legacy_up_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (root_mode && intx_valid && intx_assert) |=> irq_legacy);

  assert_all_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (!irq_msi_lo && !irq_msi_hi));
endmodule

// File: tb/msi_irq_decoder_test.sv
`timescale 1ns/1ps
module msi_irq_decoder_test;
  logic clk = 1'b0, rst_n = 1'b0, root_mode = 1'b1;
  logic msi_valid = 1'b0, intx_valid = 1'b0, intx_assert = 1'b0, reg_wr = 1'b0;
  logic [31:0] msi_data = '0, reg_wdata = '0;
  logic [3:0] msi_first_be = '0;
  logic [1:0] intx_pin = '0, reg_addr = '0;
  logic [31:0] reg_rdata;
  logic irq_msi_lo, irq_msi_hi, irq_legacy;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  msi_irq_decoder uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a; #0.1; v = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic msi(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk); msi_valid = 1; msi_data = d; msi_first_be = be;
    @(negedge clk); msi_valid = 0;
  endtask

  task automatic intx(input logic [1:0] p, input logic a);
    @(negedge clk); intx_valid = 1; intx_pin = p; intx_assert = a;
    @(negedge clk); intx_valid = 0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 pend lo", v, 0);
    rd(1, v); chk("R1 pend hi", v, 0);
    rd(2, v); chk("R1/R10 mask lo", v, 32'hFFFF_FFFF);
    rd(3, v); chk("R1/R10 mask hi", v, 32'hFFFF_FFFF);
    chk("R1 outs", {irq_msi_lo, irq_msi_hi, irq_legacy}, 0);
  endtask

  task automatic t_msi_basic;
    logic [31:0] v;
    msi(32'h0000_0005, 4'hF);
    chk("R8 masked line stays low", irq_msi_lo, 0);
    rd(0, v); chk("R8 masked vector pends", v, 32'h20);
    wr(2, 0); wr(3, 0);
    rd(2, v); chk("R8 mask lo written", v, 0);
    chk("R7 lo line", {irq_msi_lo, irq_msi_hi}, 2'b10);
    msi(32'hABCD_FF68, 4'hF);
    rd(1, v); chk("R2 vector 40 pends", v, 32'h100);
    chk("R7 hi line", irq_msi_hi, 1);
  endtask

  task automatic t_bad_be;
    logic [31:0] v;
    msi(32'h7, 4'b0111);
    msi(32'h27, 4'b0000);
    rd(0, v); chk("R3 bad BE lo", v, 32'h20);
    rd(1, v); chk("R3 bad BE hi", v, 32'h100);
  endtask

  task automatic t_clear;
    logic [31:0] v;
    wr(0, 32'h20);
    rd(0, v); chk("R5 cleared lo", v, 0);
    chk("R7 lo line drops", irq_msi_lo, 0);
    rd(1, v); chk("R5 hi untouched", v, 32'h100);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    msi(32'h9, 4'hF);
    @(negedge clk);
    msi_valid = 1; msi_data = 32'h3; msi_first_be = 4'hF;
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h208;
    @(negedge clk); msi_valid = 0; reg_wr = 0;
    rd(0, v); chk("R6 set wins over clear", v, 32'h8);
  endtask

  task automatic t_mask;
    logic [31:0] v;
    wr(3, 32'h100);
    chk("R8 masked hi line", irq_msi_hi, 0);
    rd(1, v); chk("R8 pending kept", v, 32'h100);
    rd(3, v); chk("R10 mask hi read", v, 32'h100);
  endtask

  task automatic t_endpoint;
    logic [31:0] v;
    root_mode = 0;
    msi(32'hC, 4'hF);
    intx(2'd0, 1);
    rd(0, v); chk("R4 msi ignored", v, 32'h8);
    chk("R4 intx ignored", irq_legacy, 0);
    root_mode = 1;
  endtask

  task automatic t_intx;
    intx(2'd1, 1); chk("R9 INTB up", irq_legacy, 1);
    intx(2'd3, 1);
    intx(2'd1, 0); chk("R9 INTD holds", irq_legacy, 1);
    intx(2'd3, 0); chk("R9 all down", irq_legacy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_msi_basic();
    t_bad_be();
    t_clear();
    t_collide();
    t_mask();
    t_endpoint();
    t_intx();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule